// File: doc/BRIEF.md
# Start-End Region Protection Unit with Address Probe

This unit guards a memory space with a small set of regions, each described by an inclusive first granule and an inclusive last granule of 32 bytes. Software reaches each region's start, end and permission fields through one selection register, so a single narrow register port covers all regions. Every incoming access (address, kind, privilege) is compared against all regions at once and gets a registered verdict: allow, deny, or overlap error when more than one valid region claims the address. Regions have equal standing and overlap is a programming error, not a priority choice.

A probe register lets software ask which region contains an address. Writing the address loads the selection register with the region's number, or raises a no-match or multi-match flag. A default attribute field governs addresses that no region covers, so protection is always in force.

Top module: `span_prot_unit`

## Requirements
- R1: After reset every region is invalid, the default attribute is 0, the selection register reads 0, and every access is denied.
- R2: Register address (reg_addr_i) 0 holds the default attribute in bits [5:0]; 1 is the selection register; 2, 3 and 4 are the start, end and permission fields of the region named by selection bits [IW-1:0]; 5 is the probe. Start and end keep address bits [31:5] and read 0 in bits [4:0].
- R3: The permission field stores valid in bit 0, the attribute in bits [6:1], a security flag in bit 15 and an 8-bit stream tag in bits [23:16]; all other bits read 0.
- R4: Attribute bit 3*priv+kind grants access, with kind 0 read, 1 write, 2 execute and priv 0 user, 1 kernel; kind 3 is never granted.
- R5: A valid region matches an address when start granule <= address bits [31:5] <= end granule; address bits [4:0] are ignored.
- R6: With exactly one matching region, the result is allow (code 0) when its attribute grants the access and deny (code 1) otherwise.
- R7: With no matching region, the default attribute decides the result.
- R8: With two or more matching regions, the result is overlap error (code 2) whatever the attributes.
- R9: chk_valid_o is high exactly in the cycle after chk_valid_i is sampled high.
- R10: A probe write with one matching region loads the selection index and clears bits 31 and 30; with none it sets bit 31 and clears bit 30; with several it sets bit 30 and clears bit 31; in both failure cases the index field is unchanged.
- R11: Writing the selection register sets the index field and clears both probe flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| chk_valid_i | input | 1 | Access check request |
| chk_addr_i | input | AW | Access address |
| chk_kind_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| chk_priv_i | input | 1 | 1 kernel, 0 user |
| chk_valid_o | output | 1 | Verdict valid |
| chk_result_o | output | 2 | 0 allow, 1 deny, 2 overlap error |

## Verification
The assertions watch on every cycle that a verdict follows each request by one cycle and never appears uninvited, that an overlap among matching regions always yields the error code and never otherwise, and that the probe flags stay exclusive and follow a unique hit or a miss. What only the bench scenarios show is the value side: that each attribute bit grants exactly its kind and privilege, that inclusive end granules and ignored low address bits fall where stated, that register fields read back in their positions, and that a failed probe leaves the index untouched. The bench sweeps every granule of a small window with both granule edges, all kinds and privileges, across two region layouts.

// File: rtl/spu_pkg.sv
package spu_pkg;
  localparam int unsigned ATTR_W = 6;
  localparam int unsigned SID_W  = 8;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_INDEX = 3'd1,
    REG_START = 3'd2,
    REG_END   = 3'd3,
    REG_PERM  = 3'd4,
    REG_PROBE = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    RES_ALLOW   = 2'd0,
    RES_DENY    = 2'd1,
    RES_OVERLAP = 2'd2
  } res_e;

  typedef struct packed {
    logic [SID_W-1:0]  sid;
    logic              sec;
    logic [ATTR_W-1:0] attr;
    logic              valid;
  } perm_t;
endpackage

// File: rtl/spu_region_bank.sv
module spu_region_bank
  import spu_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned GW = 27,
  parameter int unsigned IW = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_start_i,
  input  logic                   wr_end_i,
  input  logic                   wr_perm_i,
  input  logic [IW-1:0]          sel_i,
  input  logic [GW-1:0]          gran_i,
  input  perm_t                  perm_i,
  output logic [N-1:0][GW-1:0]   start_o,
  output logic [N-1:0][GW-1:0]   end_o,
  output perm_t [N-1:0]          perm_o
);
  for (genvar g = 0; g < N; g++) begin : g_rgn
    localparam logic [IW-1:0] SEL = IW'(g);
    logic [GW-1:0] start_q, end_q;
    perm_t         perm_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_q <= '0;
        end_q   <= '0;
        perm_q  <= '0;
      end else if (sel_i == SEL) begin
        if (wr_start_i) start_q <= gran_i;
        if (wr_end_i)   end_q   <= gran_i;
        if (wr_perm_i)  perm_q  <= perm_i;
      end
    end

    assign start_o[g] = start_q;
    assign end_o[g]   = end_q;
    assign perm_o[g]  = perm_q;
  end
endmodule

// File: rtl/spu_match.sv
module spu_match #(
  parameter int unsigned N  = 4,
  parameter int unsigned GW = 27
) (
  input  logic [GW-1:0]        gran_i,
  input  logic [N-1:0][GW-1:0] start_i,
  input  logic [N-1:0][GW-1:0] end_i,
  input  logic [N-1:0]         valid_i,
  output logic [N-1:0]         hit_o
);
  // inclusive on both granule bounds
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (gran_i >= start_i[g]) && (gran_i <= end_i[g]);
  end
endmodule

// File: rtl/spu_decide.sv
module spu_decide
  import spu_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]             hit_i,
  input  logic [N-1:0][ATTR_W-1:0] attr_i,
  input  logic [ATTR_W-1:0]        dflt_i,
  input  logic [1:0]               kind_i,
  input  logic                     priv_i,
  output res_e                     res_o
);
  logic [ATTR_W-1:0] sel_attr, eff_attr;
  logic              multi, grant;
  logic [2:0]        bit_idx;

  always_comb begin
    sel_attr = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_i[i]) sel_attr = sel_attr | attr_i[i];
    end
    multi    = |(hit_i & (hit_i - N'(1)));
    eff_attr = (|hit_i) ? sel_attr : dflt_i;
    bit_idx  = priv_i ? (3'd3 + {1'b0, kind_i}) : {1'b0, kind_i};
    grant    = (kind_i != 2'd3) ? eff_attr[bit_idx] : 1'b0;
    if (multi)      res_o = RES_OVERLAP;
    else if (grant) res_o = RES_ALLOW;
    else            res_o = RES_DENY;
  end
endmodule

// File: rtl/span_prot_unit.sv
module span_prot_unit
  import spu_pkg::*;
#(
  parameter int unsigned N_REGIONS = 4,
  parameter int unsigned AW        = 32,
  parameter int unsigned GRAN_BITS = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          chk_valid_i,
  input  logic [AW-1:0] chk_addr_i,
  input  logic [1:0]    chk_kind_i,
  input  logic          chk_priv_i,
  output logic          chk_valid_o,
  output logic [1:0]    chk_result_o
);
  localparam int unsigned IW = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1;
  localparam int unsigned GW = AW - GRAN_BITS;

  logic [N_REGIONS-1:0][GW-1:0]     start_q, end_q;
  perm_t [N_REGIONS-1:0]            perm_q;
  logic [N_REGIONS-1:0]             valid_v;
  logic [N_REGIONS-1:0][ATTR_W-1:0] attr_v;
  logic [N_REGIONS-1:0]             probe_hit, chk_hit;

  logic [ATTR_W-1:0] ctrl_attr_q;
  logic [IW-1:0]     idx_q, probe_idx;
  logic              nomatch_q, multi_q;
  logic              probe_we, probe_none, probe_multi, idx_ok;
  logic [GW-1:0]     wr_gran;
  perm_t             wr_perm;
  res_e              res;
  logic [1:0]        res_q;
  logic              rvalid_q;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = ^chk_addr_i[GRAN_BITS-1:0];

  assign wr_gran       = reg_wdata_i[AW-1:GRAN_BITS];
  assign wr_perm.valid = reg_wdata_i[0];
  assign wr_perm.attr  = reg_wdata_i[ATTR_W:1];
  assign wr_perm.sec   = reg_wdata_i[15];
  assign wr_perm.sid   = reg_wdata_i[16+SID_W-1:16];
  assign probe_we      = reg_we_i && (reg_addr_i == REG_PROBE);

  spu_region_bank #(.N(N_REGIONS), .GW(GW), .IW(IW)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_start_i (reg_we_i && (reg_addr_i == REG_START)),
    .wr_end_i   (reg_we_i && (reg_addr_i == REG_END)),
    .wr_perm_i  (reg_we_i && (reg_addr_i == REG_PERM)),
    .sel_i      (idx_q),
    .gran_i     (wr_gran),
    .perm_i     (wr_perm),
    .start_o    (start_q),
    .end_o      (end_q),
    .perm_o     (perm_q)
  );

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_fld
    assign valid_v[g] = perm_q[g].valid;
    assign attr_v[g]  = perm_q[g].attr;
  end

  spu_match #(.N(N_REGIONS), .GW(GW)) i_probe_match (
    .gran_i  (wr_gran),
    .start_i (start_q),
    .end_i   (end_q),
    .valid_i (valid_v),
    .hit_o   (probe_hit)
  );

  spu_match #(.N(N_REGIONS), .GW(GW)) i_chk_match (
    .gran_i  (chk_addr_i[AW-1:GRAN_BITS]),
    .start_i (start_q),
    .end_i   (end_q),
    .valid_i (valid_v),
    .hit_o   (chk_hit)
  );

  spu_decide #(.N(N_REGIONS)) i_decide (
    .hit_i  (chk_hit),
    .attr_i (attr_v),
    .dflt_i (ctrl_attr_q),
    .kind_i (chk_kind_i),
    .priv_i (chk_priv_i),
    .res_o  (res)
  );

  always_comb begin
    probe_idx = '0;
    for (int i = 0; i < N_REGIONS; i++) begin
      if (probe_hit[i]) probe_idx = probe_idx | IW'(i);
    end
    probe_none  = ~|probe_hit;
    probe_multi = |(probe_hit & (probe_hit - N_REGIONS'(1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_attr_q <= '0;
      idx_q       <= '0;
      nomatch_q   <= 1'b0;
      multi_q     <= 1'b0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        REG_CTRL: ctrl_attr_q <= reg_wdata_i[ATTR_W-1:0];
        REG_INDEX: begin
          idx_q     <= reg_wdata_i[IW-1:0];
          nomatch_q <= 1'b0;
          multi_q   <= 1'b0;
        end
        REG_PROBE: begin
          if (probe_none) begin
            nomatch_q <= 1'b1;
            multi_q   <= 1'b0;
          end else if (probe_multi) begin
            nomatch_q <= 1'b0;
            multi_q   <= 1'b1;
          end else begin
            idx_q     <= probe_idx;
            nomatch_q <= 1'b0;
            multi_q   <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      res_q    <= RES_ALLOW;
    end else begin
      rvalid_q <= chk_valid_i;
      if (chk_valid_i) res_q <= res;
    end
  end

  assign chk_valid_o  = rvalid_q;
  assign chk_result_o = res_q;
  assign idx_ok       = int'(idx_q) < int'(N_REGIONS);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CTRL: reg_rdata_o[ATTR_W-1:0] = ctrl_attr_q;
      REG_INDEX: begin
        reg_rdata_o[31]     = nomatch_q;
        reg_rdata_o[30]     = multi_q;
        reg_rdata_o[IW-1:0] = idx_q;
      end
      REG_START: if (idx_ok) reg_rdata_o[AW-1:GRAN_BITS] = start_q[idx_q];
      REG_END:   if (idx_ok) reg_rdata_o[AW-1:GRAN_BITS] = end_q[idx_q];
      REG_PERM: if (idx_ok) begin
        reg_rdata_o[0]                = perm_q[idx_q].valid;
        reg_rdata_o[ATTR_W:1]         = perm_q[idx_q].attr;
        reg_rdata_o[15]               = perm_q[idx_q].sec;
        reg_rdata_o[16+SID_W-1:16]    = perm_q[idx_q].sid;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/spu_checker.sv
module spu_checker #(
  parameter int unsigned N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         chk_valid_i,
  input logic         chk_valid_o,
  input logic [1:0]   chk_result_o,
  input logic [N-1:0] chk_hit_i,
  input logic         probe_we_i,
  input logic [N-1:0] probe_hit_i,
  input logic         nomatch_i,
  input logic         multi_i
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i |=> chk_valid_o); // R9
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_valid_i |=> !chk_valid_o); // R9
  AST_OVERLAP_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && $countones(chk_hit_i) > 1) |=> (chk_result_o == 2'd2)); // R8
  AST_NO_FALSE_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && $countones(chk_hit_i) <= 1) |=> (chk_result_o != 2'd2)); // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nomatch_i && multi_i)); // R10
  AST_PROBE_UNIQUE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_we_i && $countones(probe_hit_i) == 1) |=> (!nomatch_i && !multi_i)); // R10
  AST_PROBE_MISS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_we_i && probe_hit_i == '0) |=> (nomatch_i && !multi_i)); // R10
endmodule

bind span_prot_unit spu_checker #(.N(N_REGIONS)) i_spu_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .chk_valid_i  (chk_valid_i),
  .chk_valid_o  (chk_valid_o),
  .chk_result_o (chk_result_o),
  .chk_hit_i    (chk_hit),
  .probe_we_i   (probe_we),
  .probe_hit_i  (probe_hit),
  .nomatch_i    (nomatch_q),
  .multi_i      (multi_q)
);

// File: tb/test_span_prot_unit.sv
`timescale 1ns/1ps
module test_span_prot_unit;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        chk_valid = 1'b0;
  logic [31:0] chk_addr = '0;
  logic [1:0]  chk_kind = '0;
  logic        chk_priv = 1'b0;
  logic        chk_valid_o;
  logic [1:0]  chk_result;

  int n_tests = 0;
  int n_fail  = 0;

  int         ss[NR], se[NR];
  logic [5:0] sa[NR];
  bit         sv[NR];
  logic [5:0] dflt;
  int         sh_idx;

  always #2.5 clk = ~clk;

  span_prot_unit i_span_prot_unit (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .chk_valid_i(chk_valid),
    .chk_addr_i(chk_addr), .chk_kind_i(chk_kind), .chk_priv_i(chk_priv),
    .chk_valid_o(chk_valid_o), .chk_result_o(chk_result)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_region(int r, int gs, int ge, logic [5:0] attr, bit v);
    reg_write(3'd1, 32'(r));
    sh_idx = r;
    reg_write(3'd2, 32'((gs << 5) | 31));
    reg_write(3'd3, 32'((ge << 5) | 7));
    reg_write(3'd4, 32'(((r + 1) << 16) | (int'(attr) << 1) | int'(v)));
    ss[r] = gs; se[r] = ge; sa[r] = attr; sv[r] = v;
  endtask

  function automatic int hit_count(int g, output int last);
    int c = 0;
    last = 0;
    for (int r = 0; r < NR; r++)
      if (sv[r] && g >= ss[r] && g <= se[r]) begin c++; last = r; end
    return c;
  endfunction

  task automatic do_chk(int g, int off, int kind, int priv);
    int last, cnt;
    logic [5:0] a;
    logic [1:0] exp;
    string tag;
    cnt = hit_count(g, last);
    if (cnt > 1) begin exp = 2'd2; tag = "R8"; end
    else begin
      a = (cnt == 1) ? sa[last] : dflt;
      tag = (cnt == 1) ? "R5 R6" : "R7";
      if (kind == 3) begin exp = 2'd1; tag = "R4"; end
      else exp = a[priv*3 + kind] ? 2'd0 : 2'd1;
    end
    @(negedge clk);
    chk_valid = 1'b1; chk_addr = 32'(g * 32 + off);
    chk_kind = 2'(kind); chk_priv = priv[0];
    @(negedge clk);
    chk_valid = 1'b0;
    check(chk_valid_o && chk_result == exp, tag, {29'(0), chk_valid_o, chk_result},
          {29'(0), 1'b1, exp});
  endtask

  task automatic sweep_checks();
    for (int g = 0; g < 64; g++)
      for (int o = 0; o < 2; o++)
        for (int k = 0; k < 4; k++)
          for (int p = 0; p < 2; p++)
            do_chk(g, o * 31, k, p);
  endtask

  task automatic sweep_probe();
    logic [31:0] rd, exp;
    int last, cnt;
    for (int g = 0; g < 64; g++) begin
      reg_write(3'd5, 32'(g * 32 + 13));
      cnt = hit_count(g, last);
      if (cnt == 1) begin sh_idx = last; exp = 32'(last); end
      else if (cnt == 0) exp = 32'h8000_0000 | 32'(sh_idx);
      else exp = 32'h4000_0000 | 32'(sh_idx);
      reg_read(3'd1, rd);
      check(rd == exp, "R10", rd, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 32'(0), 32'(1));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    for (int r = 0; r < NR; r++) begin ss[r] = 0; se[r] = 0; sa[r] = '0; sv[r] = 0; end
    dflt = '0; sh_idx = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    check(chk_valid_o == 1'b0, "R1", {31'(0), chk_valid_o}, 32'(0));
    reg_read(3'd1, rd); check(rd == 32'(0), "R1", rd, 32'(0));
    reg_read(3'd0, rd); check(rd == 32'(0), "R1", rd, 32'(0));
    reg_read(3'd4, rd); check(rd == 32'(0), "R1", rd, 32'(0));
    for (int k = 0; k < 3; k++) do_chk(7, 0, k, 1);

    // R3 permission field positions
    reg_write(3'd1, 32'd3);
    reg_write(3'd4, 32'hFFFF_FFFF);
    reg_read(3'd4, rd); check(rd == 32'h00FF_807F, "R3", rd, 32'h00FF_807F);
    reg_write(3'd4, 32'h0);

    // regions: R2 overlaps R3 on granules 28..30
    set_region(0, 4, 9, 6'h19, 1);
    set_region(1, 12, 12, 6'h3F, 1);
    set_region(2, 20, 30, 6'h07, 1);
    set_region(3, 28, 35, 6'h20, 1);
    dflt = 6'h08;
    reg_write(3'd0, 32'hFFFF_FFC8);
    reg_read(3'd0, rd); check(rd == 32'h08, "R2", rd, 32'h08);

    // R2 start/end low bits dropped, selection indirect
    reg_write(3'd1, 32'd0); sh_idx = 0;
    reg_read(3'd2, rd); check(rd == 32'h80, "R2", rd, 32'h80);
    reg_read(3'd3, rd); check(rd == 32'h120, "R2", rd, 32'h120);
    reg_write(3'd1, 32'd1); sh_idx = 1;
    reg_read(3'd2, rd); check(rd == 32'h180, "R2", rd, 32'h180);

    sweep_checks();

    // R9 verdict drops when request idle
    do_chk(12, 0, 0, 0);
    @(negedge clk);
    check(chk_valid_o == 1'b0, "R9", {31'(0), chk_valid_o}, 32'(0));

    sweep_probe();

    // R11 index write clears flags
    reg_write(3'd5, 32'(60 * 32));
    reg_read(3'd1, rd); check(rd[31] == 1'b1, "R10", rd, 32'h8000_0000 | 32'(sh_idx));
    reg_write(3'd1, 32'd2); sh_idx = 2;
    reg_read(3'd1, rd); check(rd == 32'd2, "R11", rd, 32'd2);

    // second layout: region 3 invalid, open default
    set_region(3, 28, 35, 6'h20, 0);
    dflt = 6'h3F;
    reg_write(3'd0, 32'h3F);
    sweep_checks();
    sweep_probe();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule